// File: doc/BRIEF.md
# Framebuffer Window Fetch Address Sequencer

This block produces the stream of memory read bursts needed to pull a visible display window out of a framebuffer that may be wider than the window. Software programs a set of staged registers: the start address, the frame length in 32-bit words, the burst size, the number of words in one visible line, a byte skip added after each visible line, and the sub-word bit position of the first pixel. The sequencer then issues word-aligned burst requests on a request/grant port. Each request stays on the port until it is granted. When the whole frame has been granted, the sequencer starts again at the start address.

Staged settings do not reach the running sequencer when they are written. Software sets an update flag, and the staged set is copied into the active set at the next frame boundary, after which the flag clears itself. A busy output shows that a frame fetch is in progress. Software clears the enable bit and waits for busy to drop before it reprograms. A separate abort bit stops a fetch at once. The pixel FIFO, pixel unpacking and display timing are handled elsewhere. This block produces only addresses, burst lengths and the frame sequencing.

Top module: `fb_window_fetch`

## Requirements
- R1: After reset, mem_req, busy and upd_pending are 0 and pix_offset is 0.
- R2: Every request address has its two low bits cleared. The first burst of a frame starts at the start address (register select 0) with bits 1:0 dropped. Outside a line skip, each further burst starts at the previous address plus 4 × the previous burst length.
- R3: The burst length is the value in bits 30:24 of the frame register (select 1) plus one, capped only as R4 and R5 describe. After reset it is 8 words.
- R4: The frame length in words is taken from bits 22:0 of the frame register. The word counts granted in one frame add up to exactly this value, and the last burst is shortened to the words that remain. A frame length of 0 starts no fetch.
- R5: 2D mode is set by control bit 4 (control register, select 2). In this mode, with a nonzero line width (select 4, bits 15:0), no burst crosses the end of a visible line. After the last word of a line, the address moves on by the skip (select 3, bits 15:0, bits 1:0 ignored) on top of the normal step.
- R6: pix_offset shows bits 28:24 of select 3 once the staged set has been applied.
- R7: Writes to the staged registers have no effect until control bit 3 (update) is written as 1. upd_pending then goes high and stays high through a running frame. The staged set is applied when the next frame starts, and upd_pending returns to 0 in the same clock.
- R8: A request whose grant is low keeps mem_req, mem_addr and mem_len unchanged in the next cycle.
- R9: busy is high from the first request of a frame until its last burst is granted. With enable set, a new frame starts after one idle cycle, at the start address again.
- R10: Clearing the enable bit (control bit 0) lets a running frame finish and starts no further frame.
- R11: Writing 1 to control bit 1 (abort) drops mem_req and busy in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 start, 1 frame, 2 control, 3 skip/offset, 4 line width |
| cfg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Burst read request |
| mem_addr | output | 32 | Byte address of the burst, word aligned |
| mem_len | output | 8 | Burst length in words |
| mem_gnt | input | 1 | Grant; a burst is accepted on a clock where mem_req and mem_gnt are both high |
| busy | output | 1 | Frame fetch in progress |
| pix_offset | output | 5 | Bit position of the first pixel in the first word |
| upd_pending | output | 1 | Staged update waiting for a frame boundary |

## Verification
The assertions assume that mem_gnt is meaningful only while mem_req is high. They also assume that abort is the only thing that can take a request off the port before it is granted, so the hold property is disabled in any cycle that carries an abort write. In 2D mode the stimulus uses a nonzero line width and skips that are multiples of four, apart from one case that checks the ignored low skip bits. Grants are either always high or random, so stalls of any length occur. Configuration is always changed with a staged write followed by an update, either while idle or during a frame.

// File: rtl/fbw_pkg.sv
// Shared widths, register map constants and types for the window fetch sequencer.
// Assumes 32-bit words and byte addressing.
package fbw_pkg;
    parameter int FBW_ADDR_W = 32;
    parameter int FBW_SIZE_W = 23;
    parameter int FBW_BLEN_W = 7;
    parameter int FBW_SKIP_W = 16;
    parameter int FBW_POFF_W = 5;
    parameter int FBW_LINE_W = 16;
    parameter int FBW_SEL_W  = 3;
    parameter int FBW_DATA_W = 32;

    // register selects
    localparam logic [FBW_SEL_W-1:0] SEL_START = 3'd0;
    localparam logic [FBW_SEL_W-1:0] SEL_FRAME = 3'd1;
    localparam logic [FBW_SEL_W-1:0] SEL_CTRL  = 3'd2;
    localparam logic [FBW_SEL_W-1:0] SEL_SKIP  = 3'd3;
    localparam logic [FBW_SEL_W-1:0] SEL_LINE  = 3'd4;

    // field positions
    localparam int BLEN_LSB = 24;
    localparam int POFF_LSB = 24;
    localparam int CTRL_EN  = 0;
    localparam int CTRL_ABT = 1;
    localparam int CTRL_UPD = 3;
    localparam int CTRL_2D  = 4;

    typedef struct packed {
        logic [FBW_ADDR_W-1:0] start;
        logic [FBW_SIZE_W-1:0] size;
        logic [FBW_BLEN_W-1:0] blen_m1;
        logic [FBW_SKIP_W-1:0] skip;
        logic [FBW_POFF_W-1:0] poff;
        logic [FBW_LINE_W-1:0] line;
        logic                  two_d;
    } fbw_cfg_t;

    localparam fbw_cfg_t FBW_CFG_RESET = '{
        start: '0, size: '0, blen_m1: FBW_BLEN_W'(7),
        skip: '0, poff: '0, line: '0, two_d: 1'b0
    };

    typedef enum logic {ST_IDLE = 1'b0, ST_FETCH = 1'b1} fbw_state_e;
endpackage

// File: rtl/fbw_regs.sv
// Staged register file. Holds the software-written configuration and the enable
// bit, and tracks the pending update flag. Abort is decoded straight from the write.
// Assumes one write per clock; the update set wins over a take in the same clock.
module fbw_regs
    import fbw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [FBW_SEL_W-1:0]  sel,
    input  logic [FBW_DATA_W-1:0] wdata,
    input  logic                  take_upd,
    output fbw_cfg_t              staged,
    output logic                  en,
    output logic                  abort,
    output logic                  pending
);
    logic ctrl_wr;
    logic unused_wdata;

    assign ctrl_wr      = we && (sel == SEL_CTRL);
    assign abort        = ctrl_wr && wdata[CTRL_ABT];
    assign unused_wdata = ^wdata;

    // staged configuration and enable bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged <= FBW_CFG_RESET;
            en     <= 1'b0;
        end else if (we) begin
            case (sel)
                SEL_START: staged.start <= wdata[FBW_ADDR_W-1:0];
                SEL_FRAME: begin
                    staged.size    <= wdata[FBW_SIZE_W-1:0];
                    staged.blen_m1 <= wdata[BLEN_LSB +: FBW_BLEN_W];
                end
                SEL_CTRL: begin
                    en           <= wdata[CTRL_EN];
                    staged.two_d <= wdata[CTRL_2D];
                end
                SEL_SKIP: begin
                    staged.skip <= wdata[FBW_SKIP_W-1:0];
                    staged.poff <= wdata[POFF_LSB +: FBW_POFF_W];
                end
                SEL_LINE:  staged.line <= wdata[FBW_LINE_W-1:0];
                default: ;
            endcase
        end
    end

    // pending update flag: set by software, cleared when the sequencer takes it
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (ctrl_wr && wdata[CTRL_UPD])
            pending <= 1'b1;
        else if (take_upd)
            pending <= 1'b0;
    end
endmodule

// File: rtl/fbw_burst_len.sv
// Burst length selector: the smallest of the programmed burst, the words left in
// the frame and, when line capping is on, the words left in the current line.
// Assumes remaining and line_left are nonzero while used.
module fbw_burst_len
    import fbw_pkg::*;
#(
    parameter int LEN_W = FBW_BLEN_W + 1
) (
    input  logic [FBW_BLEN_W-1:0] blen_m1,
    input  logic [FBW_SIZE_W-1:0] remaining,
    input  logic [FBW_LINE_W-1:0] line_left,
    input  logic                  line_cap,
    output logic [LEN_W-1:0]      len
);
    // pick the tightest of the three limits
    always_comb begin
        len = LEN_W'(blen_m1) + LEN_W'(1);
        if (remaining < FBW_SIZE_W'(len))
            len = LEN_W'(remaining);
        if (line_cap && (line_left < FBW_LINE_W'(len)))
            len = LEN_W'(line_left);
    end
endmodule

// File: rtl/fbw_seq.sv
// Frame sequencer. Holds the active configuration, starts a frame when enabled,
// walks the address through bursts and line skips, and ends the frame when every
// word has been granted. Assumes grant is only acted on while requesting.
module fbw_seq
    import fbw_pkg::*;
#(
    parameter int LEN_W = FBW_BLEN_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic                  abort,
    input  logic                  pending,
    input  fbw_cfg_t              staged,
    input  logic                  gnt,
    output logic                  take_upd,
    output logic                  req,
    output logic [FBW_ADDR_W-1:0] addr,
    output logic [LEN_W-1:0]      len,
    output logic                  busy,
    output logic [FBW_POFF_W-1:0] poff
);
    fbw_state_e            state_q;
    fbw_cfg_t              active_q;
    fbw_cfg_t              eff;
    logic [FBW_ADDR_W-1:0] addr_q;
    logic [FBW_SIZE_W-1:0] rem_q;
    logic [FBW_LINE_W-1:0] line_q;
    logic                  use_2d;
    logic                  start;
    logic [FBW_SIZE_W-1:0] rem_next;
    logic [FBW_LINE_W-1:0] line_next;
    logic [FBW_ADDR_W-1:0] addr_step;
    logic [FBW_ADDR_W-1:0] skip_bytes;
    logic                  unused_cfg;

    assign use_2d     = active_q.two_d && (active_q.line != '0);
    assign eff        = pending ? staged : active_q;
    assign take_upd   = (state_q == ST_IDLE) && en && pending && !abort;
    assign start      = (state_q == ST_IDLE) && en && !abort && (eff.size != '0);
    assign rem_next   = rem_q - FBW_SIZE_W'(len);
    assign line_next  = line_q - FBW_LINE_W'(len);
    assign addr_step  = addr_q + (FBW_ADDR_W'(len) << 2);
    assign skip_bytes = FBW_ADDR_W'({active_q.skip[FBW_SKIP_W-1:2], 2'b00});
    assign unused_cfg = ^{active_q.start[1:0], active_q.skip[1:0], eff.blen_m1,
                          eff.skip, eff.poff, eff.two_d};

    fbw_burst_len #(.LEN_W(LEN_W)) u_len (
        .blen_m1   (active_q.blen_m1),
        .remaining (rem_q),
        .line_left (line_q),
        .line_cap  (use_2d),
        .len       (len)
    );

    // frame state, active configuration and address walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            active_q <= FBW_CFG_RESET;
            addr_q   <= '0;
            rem_q    <= '0;
            line_q   <= '0;
        end else if (abort) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (take_upd)
                        active_q <= staged;
                    if (start) begin
                        state_q <= ST_FETCH;
                        addr_q  <= {eff.start[FBW_ADDR_W-1:2], 2'b00};
                        rem_q   <= eff.size;
                        line_q  <= eff.line;
                    end
                end
                ST_FETCH: begin
                    if (gnt) begin
                        rem_q <= rem_next;
                        if (rem_next == '0)
                            state_q <= ST_IDLE;
                        if (use_2d && (line_next == '0)) begin
                            addr_q <= addr_step + skip_bytes;
                            line_q <= active_q.line;
                        end else begin
                            addr_q <= addr_step;
                            line_q <= line_next;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state_q == ST_FETCH);
    assign req  = busy;
    assign addr = addr_q;
    assign poff = active_q.poff;
endmodule

// File: rtl/fb_window_fetch.sv
// Top of the framebuffer window fetch sequencer: staged registers feeding a frame
// sequencer that drives a request/grant burst read port.
// Assumes a single clock and a synchronous active-low reset.
module fb_window_fetch
    import fbw_pkg::*;
#(
    parameter int LEN_W = FBW_BLEN_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [FBW_SEL_W-1:0]  cfg_sel,
    input  logic [FBW_DATA_W-1:0] cfg_wdata,
    output logic                  mem_req,
    output logic [FBW_ADDR_W-1:0] mem_addr,
    output logic [LEN_W-1:0]      mem_len,
    input  logic                  mem_gnt,
    output logic                  busy,
    output logic [FBW_POFF_W-1:0] pix_offset,
    output logic                  upd_pending
);
    fbw_cfg_t staged;
    logic     en;
    logic     abort;
    logic     take_upd;

    fbw_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .sel      (cfg_sel),
        .wdata    (cfg_wdata),
        .take_upd (take_upd),
        .staged   (staged),
        .en       (en),
        .abort    (abort),
        .pending  (upd_pending)
    );

    fbw_seq #(.LEN_W(LEN_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .abort    (abort),
        .pending  (upd_pending),
        .staged   (staged),
        .gnt      (mem_gnt),
        .take_upd (take_upd),
        .req      (mem_req),
        .addr     (mem_addr),
        .len      (mem_len),
        .busy     (busy),
        .poff     (pix_offset)
    );
endmodule

// File: rtl/fb_window_fetch_chk.sv
// Property checker for the window fetch sequencer, bound to the top module.
// Assumes abort is the only way to withdraw an ungranted request.
module fb_window_fetch_chk
    import fbw_pkg::*;
#(
    parameter int LEN_W = FBW_BLEN_W + 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_we,
    input logic [FBW_SEL_W-1:0]  cfg_sel,
    input logic [FBW_DATA_W-1:0] cfg_wdata,
    input logic                  mem_req,
    input logic [FBW_ADDR_W-1:0] mem_addr,
    input logic [LEN_W-1:0]      mem_len,
    input logic                  mem_gnt,
    input logic                  busy,
    input logic [FBW_POFF_W-1:0] pix_offset,
    input logic                  upd_pending
);
    logic abort_now;
    assign abort_now = cfg_we && (cfg_sel == SEL_CTRL) && cfg_wdata[CTRL_ABT];

    // R2: addresses are word aligned
    a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R3: a request never carries zero words
    a_r3_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_len != '0));

    // R8: ungranted request is held stable
    a_r8_hold_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt && !abort_now) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_len)));

    // R9: busy only ends on a grant or an abort
    a_r9_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(mem_gnt) || $past(abort_now)));

    // R7: pending update is only taken while idle
    a_r7_take_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(upd_pending) |-> !$past(busy));

    // R11: abort removes the request next cycle
    a_r11_abort_drop: assert property (@(posedge clk) disable iff (!rst_n)
        abort_now |=> !mem_req);

    // R6: pixel offset only moves at a frame boundary
    a_r6_poff_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> $stable(pix_offset));
endmodule

bind fb_window_fetch fb_window_fetch_chk #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/tb_fb_window_fetch.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared against the design on every clock.
module tb_fb_window_fetch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [7:0]  mem_len;
    logic        mem_gnt = 1'b0;
    logic        busy;
    logic [4:0]  pix_offset;
    logic        upd_pending;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string sec = "R1";
    bit gnt_rand = 1'b0;
    int words_dut = 0;

    always #10 clk = ~clk;

    fb_window_fetch dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_len(mem_len), .mem_gnt(mem_gnt), .busy(busy),
        .pix_offset(pix_offset), .upd_pending(upd_pending)
    );

    // ---------------- reference model ----------------
    bit          m_busy, m_en, m_pend;
    logic [31:0] m_addr;
    int          m_rem, m_line;
    logic [31:0] s_start, a_start;
    int          s_size, a_size, s_blen, a_blen, s_skip, a_skip;
    int          s_poff, a_poff, s_line, a_line;
    bit          s_2d, a_2d;

    function automatic int mlen();
        int c;
        c = a_blen + 1;
        if (m_rem < c) c = m_rem;
        if (a_2d && a_line != 0 && m_line < c) c = m_line;
        return c;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_en = 0; m_pend = 0; m_addr = 0; m_rem = 0; m_line = 0;
            s_start = 0; s_size = 0; s_blen = 7; s_skip = 0; s_poff = 0; s_line = 0; s_2d = 0;
            a_start = 0; a_size = 0; a_blen = 7; a_skip = 0; a_poff = 0; a_line = 0; a_2d = 0;
        end else begin
            bit ab;
            int l, esize, eline;
            logic [31:0] estart;
            ab = cfg_we && cfg_sel == 3'd2 && cfg_wdata[1];
            l = mlen();
            estart = m_pend ? s_start : a_start;
            esize  = m_pend ? s_size : a_size;
            eline  = m_pend ? s_line : a_line;
            if (ab) begin
                m_busy = 0;
            end else if (!m_busy) begin
                if (m_en && m_pend) begin
                    a_start = s_start; a_size = s_size; a_blen = s_blen; a_skip = s_skip;
                    a_poff = s_poff; a_line = s_line; a_2d = s_2d; m_pend = 0;
                end
                if (m_en && esize != 0) begin
                    m_busy = 1; m_addr = estart & 32'hFFFF_FFFC; m_rem = esize; m_line = eline;
                end
            end else if (mem_gnt) begin
                m_rem  = m_rem - l;
                m_line = m_line - l;
                m_addr = m_addr + 32'(4 * l);
                if (m_rem == 0) m_busy = 0;
                if (a_2d && a_line != 0 && m_line == 0) begin
                    m_addr = m_addr + 32'(a_skip & 32'hFFFC);
                    m_line = a_line;
                end
            end
            if (cfg_we) begin
                case (cfg_sel)
                    3'd0: s_start = cfg_wdata;
                    3'd1: begin s_size = int'(cfg_wdata[22:0]); s_blen = int'(cfg_wdata[30:24]); end
                    3'd2: begin
                        m_en = cfg_wdata[0]; s_2d = cfg_wdata[4];
                        if (cfg_wdata[3]) m_pend = 1;
                    end
                    3'd3: begin s_skip = int'(cfg_wdata[15:0]); s_poff = int'(cfg_wdata[28:24]); end
                    3'd4: s_line = int'(cfg_wdata[15:0]);
                    default: ;
                endcase
            end
        end
    end

    // ---------------- per-clock compare, grant driver, word count ----------------
    logic       prev_req = 1'b0;
    logic [7:0] prev_len = '0;

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", sec, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_gnt && prev_req) words_dut += int'(prev_len);
            chk(mem_req == m_busy, "R8 mem_req", mem_req, m_busy);
            chk(busy == m_busy, "R9 busy", busy, m_busy);
            chk(upd_pending == m_pend, "R7 upd_pending", upd_pending, m_pend);
            chk(int'(pix_offset) == a_poff, "R6 pix_offset", pix_offset, a_poff);
            if (m_busy) begin
                chk(mem_addr == m_addr, "R2/R5 mem_addr", mem_addr, m_addr);
                chk(int'(mem_len) == mlen(), "R3/R4 mem_len", mem_len, mlen());
            end
        end
        prev_req = mem_req;
        prev_len = mem_len;
        mem_gnt  = gnt_rand ? ($urandom_range(0, 2) == 0) : 1'b1;
    end

    // ---------------- helpers ----------------
    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic wait_busy(input bit lvl);
        while (busy != lvl) step();
    endtask

    task automatic frame_words(input int exp, input string tag);
        int w0;
        wait_busy(1);
        w0 = words_dut - ((mem_gnt && prev_req) ? 0 : 0);
        w0 = words_dut;
        wait_busy(0);
        chk((words_dut - w0) == exp, {tag, " words per frame"}, words_dut - w0, exp);
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog expired act=%0d exp=<150000", cycles);
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        sec = "R1";
        chk(!mem_req && !busy && !upd_pending && pix_offset == 0, "R1 reset outputs",
            {mem_req, busy, upd_pending, pix_offset}, 0);

        // R3/R4/R2: default burst 8, 20 words, unaligned start
        sec = "R3";
        wr(3'd0, 32'h0000_1003);
        wr(3'd1, {1'b0, 7'd7, 1'b0, 23'd20});
        wr(3'd2, 32'h9);                 // enable + update
        frame_words(20, "R4");
        sec = "R9";
        frame_words(20, "R9 restart");
        // R10: clear enable mid-frame
        sec = "R10";
        wait_busy(1);
        wr(3'd2, 32'h0);
        wait_busy(0);
        repeat (40) step();
        chk(!busy && !mem_req, "R10 no new frame", busy, 0);

        // R8: stalls with random grant, burst 5, 13 words
        sec = "R8";
        gnt_rand = 1'b1;
        wr(3'd0, 32'h0002_0000);
        wr(3'd1, {1'b0, 7'd4, 1'b0, 23'd13});
        wr(3'd2, 32'h9);
        frame_words(13, "R4 stalls");
        frame_words(13, "R8 second");
        wr(3'd2, 32'h0);
        wait_busy(0);

        // R5/R6: 2D, line 6, skip 0x0A (low bits ignored), burst 4, 18 words, offset 13
        sec = "R5";
        wr(3'd0, 32'h0003_0000);
        wr(3'd1, {1'b0, 7'd3, 1'b0, 23'd18});
        wr(3'd3, {3'b0, 5'd13, 8'd0, 16'h000A});
        wr(3'd4, 32'd6);
        wr(3'd2, 32'h19);                // enable + update + 2D
        wait_busy(1);
        sec = "R6";
        chk(pix_offset == 5'd13, "R6 offset applied", pix_offset, 13);
        sec = "R5";
        frame_words(18, "R5 2D");

        // R7: staged changes during a frame, update pending across frame
        sec = "R7";
        gnt_rand = 1'b0;
        wait_busy(1);
        wr(3'd0, 32'h0004_0000);
        wr(3'd1, {1'b0, 7'd15, 1'b0, 23'd40});
        wr(3'd2, 32'h01);                // enable, 2D off, no update
        chk(pix_offset == 5'd13, "R7 offset unchanged without update", pix_offset, 13);
        wr(3'd2, 32'h09);                // update
        chk(upd_pending == 1'b1, "R7 pending held in frame", upd_pending, 1);
        wait_busy(0);
        wait_busy(1);
        chk(upd_pending == 1'b0, "R7 pending cleared at start", upd_pending, 0);
        chk(mem_addr == 32'h0004_0000, "R7 new start used", mem_addr, 32'h0004_0000);
        wait_busy(0);
        frame_words(40, "R7 new size");

        // R11: abort mid-frame
        sec = "R11";
        wr(3'd1, {1'b0, 7'd7, 1'b0, 23'd2000});
        wr(3'd2, 32'h09);
        wait_busy(1);
        repeat (5) step();
        wr(3'd2, 32'h02);                // abort, enable off
        chk(!busy && !mem_req, "R11 abort drops request", busy, 0);
        repeat (10) step();
        chk(!busy, "R11 stays idle", busy, 0);

        // R4: zero frame length starts nothing
        sec = "R4";
        wr(3'd1, 32'h0);
        wr(3'd2, 32'h09);
        repeat (20) step();
        chk(!busy && !upd_pending, "R4 zero size idle", {busy, upd_pending}, 0);

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule